// File: doc/BRIEF.md
# Dual-Core Thermal Throttle Arbiter

This block decides how the two cores of a package are slowed down when something gets too hot. Each core's thermal sensor reports an over-trip flag. Each core has two throttle methods that can be enabled on their own: clock modulation and a forced move to the lowest performance state. The package has a single shared, bidirectional, active-low hot pin. The block pulls this pin low whenever either core trips. Another agent on the board can also pull the pin low to ask the package to throttle.

The block samples the pin through a two-flop synchronizer. It treats a low pin as an outside request only when it has not driven the pin itself during the synchronizer's window. From the trip flags, the enables and the recognised outside request, it produces one registered set of outputs: a drive enable for the pin, and for each core a clock-modulation enable and a lowest-performance-state request. Two things lie outside this block: the modulation duty pattern and the machinery that carries out a performance-state change.

Top module: `thermal_throttle_arbiter`

## Requirements
- R1: `hot_drive_o` is 1 in the cycle after any `trip_i` bit is 1, and 0 in the cycle after all `trip_i` bits are 0.
- R2: When a core has only clock modulation enabled (`clkmod_en_i[i]`=1, `pstate_en_i[i]`=0) and there is no outside request, `clkmod_o[i]` is 1 exactly when that core's own `trip_i[i]` was 1 in the previous cycle. A trip on the other core does not modulate it.
- R3: A core with `pstate_en_i[i]`=1 gets `pstate_low_o[i]`=1 one cycle after any core trips, whichever core tripped.
- R4: A low level on `hot_pin_n_i` while the block is not driving is an outside request. It reaches the outputs on the third rising edge after the pin goes low. Every core with clock modulation enabled is then modulated, and every core with the performance-state method enabled is forced to its lowest state.
- R5: A low pin is never taken as an outside request while `hot_drive_o` is 1, nor during the two cycles after it falls.
- R6: A core with neither method enabled gets no throttle output, while `hot_drive_o` still follows its trip.
- R7: A core with both methods enabled that is forced to its lowest performance state also has `clkmod_o[i]`=1.
- R8: Every throttle output returns to 0 one cycle after the last trip is removed, provided there is no outside request.
- R9: During reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trip_i | input | NCORE | Per-core sensor over-trip flag |
| clkmod_en_i | input | NCORE | Per-core clock-modulation method enable |
| pstate_en_i | input | NCORE | Per-core lowest-performance-state method enable |
| hot_pin_n_i | input | 1 | Sampled level of the shared active-low hot pin |
| hot_drive_o | output | 1 | 1 = pull the hot pin low |
| clkmod_o | output | NCORE | Per-core clock-modulation enable |
| pstate_low_o | output | NCORE | Per-core force-lowest-performance-state request |

## Verification
Several properties are checked on every cycle: the pin drive tracks the trip flags one cycle later, a core with no method enabled never gets a throttle output, a tripping core with clock modulation enabled is modulated, a core with both methods enabled gets both outputs, everything goes idle one cycle after the causes are gone, and the outside request is masked while the block drives. The bench sweeps every combination of trips, enables and outside drive in a two-core configuration. Only these scenarios show the package-wide versus per-core choice as a whole, the exact three-edge latency of an outside request, and the absence of a false outside request while the pin recovers after the block releases it.

// File: rtl/thermal_arb_pkg.sv
package thermal_arb_pkg;
    // Which throttle methods a core has enabled: {pstate, clkmod}
    typedef enum logic [1:0] {
        METH_NONE = 2'b00,
        METH_CLK  = 2'b01,
        METH_PST  = 2'b10,
        METH_BOTH = 2'b11
    } method_e;
endpackage

// File: rtl/hot_pin_sync.sv
module hot_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n_i,
    input  logic drive_i,
    output logic ext_req_o
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic [STAGES-1:0] hist;
    } sync_t;

    sync_t st_d, st_q;
    logic  own_recent;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], pin_n_i};
        st_d.hist = {st_q.hist[STAGES-2:0], drive_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sync <= '1;
            st_q.hist <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // the synchronized level lags the pin by STAGES cycles; mask our own drive over that window
    assign own_recent = drive_i | (|st_q.hist);
    assign ext_req_o  = ~st_q.sync[STAGES-1] & ~own_recent;
endmodule

// File: rtl/core_policy.sv
module core_policy
    import thermal_arb_pkg::*;
(
    input  logic trip_self_i,
    input  logic trip_any_i,
    input  logic ext_req_i,
    input  logic clkmod_en_i,
    input  logic pstate_en_i,
    output logic clkmod_d_o,
    output logic pstate_d_o
);
    method_e meth;

    always_comb begin
        meth       = method_e'({pstate_en_i, clkmod_en_i});
        clkmod_d_o = 1'b0;
        pstate_d_o = 1'b0;
        unique case (meth)
            METH_NONE: ;
            METH_CLK:  clkmod_d_o = trip_self_i | ext_req_i;
            METH_PST:  pstate_d_o = trip_any_i | ext_req_i;
            METH_BOTH: begin
                pstate_d_o = trip_any_i | ext_req_i;
                clkmod_d_o = trip_any_i | ext_req_i;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/thermal_throttle_arbiter.sv
module thermal_throttle_arbiter #(
    parameter int NCORE       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCORE-1:0] trip_i,
    input  logic [NCORE-1:0] clkmod_en_i,
    input  logic [NCORE-1:0] pstate_en_i,
    input  logic             hot_pin_n_i,
    output logic             hot_drive_o,
    output logic [NCORE-1:0] clkmod_o,
    output logic [NCORE-1:0] pstate_low_o
);
    typedef struct packed {
        logic             drive;
        logic [NCORE-1:0] clkmod;
        logic [NCORE-1:0] pstate;
    } out_t;

    out_t             out_d, out_q;
    logic             ext_req;
    logic             trip_any;
    logic [NCORE-1:0] cm_next, ps_next;

    hot_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_n_i  (hot_pin_n_i),
        .drive_i  (out_q.drive),
        .ext_req_o(ext_req)
    );

    assign trip_any = |trip_i;

    for (genvar gi = 0; gi < NCORE; gi++) begin : g_core
        core_policy u_pol (
            .trip_self_i(trip_i[gi]),
            .trip_any_i (trip_any),
            .ext_req_i  (ext_req),
            .clkmod_en_i(clkmod_en_i[gi]),
            .pstate_en_i(pstate_en_i[gi]),
            .clkmod_d_o (cm_next[gi]),
            .pstate_d_o (ps_next[gi])
        );

        // R6: no method enabled, no action
        assert_no_method_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!clkmod_en_i[gi] && !pstate_en_i[gi]) |=> (!clkmod_o[gi] && !pstate_low_o[gi]));
        // R2: own trip with clock modulation enabled modulates the core
        assert_own_trip_mod_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (trip_i[gi] && clkmod_en_i[gi]) |=> clkmod_o[gi]);
        // R7: both methods, package trip gives both outputs
        assert_both_methods_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (trip_any && clkmod_en_i[gi] && pstate_en_i[gi]) |=> (clkmod_o[gi] && pstate_low_o[gi]));
        // R3: any trip forces the lowest state on an enabled core
        assert_pkg_pstate_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (trip_any && pstate_en_i[gi]) |=> pstate_low_o[gi]);
    end

    always_comb begin
        out_d        = out_q;
        out_d.drive  = trip_any;
        out_d.clkmod = cm_next;
        out_d.pstate = ps_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign hot_drive_o  = out_q.drive;
    assign clkmod_o     = out_q.clkmod;
    assign pstate_low_o = out_q.pstate;

    assert_drive_on_trip_R1: assert property (@(posedge clk) disable iff (!rst_n)
        trip_any |=> hot_drive_o);
    assert_drive_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !trip_any |=> !hot_drive_o);
    assert_self_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hot_drive_o |-> !ext_req);
    assert_release_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!trip_any && !ext_req) |=> (clkmod_o == '0 && pstate_low_o == '0));
endmodule

// File: tb/sim_thermal_throttle_arbiter.sv
module sim_thermal_throttle_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] trip = '0, cm_en = '0, ps_en = '0;
    logic          ext_drive = 1'b0;
    logic          hot_n;
    logic          drive;
    logic [NC-1:0] cm_o, ps_o;
    int            n_cmp = 0, n_bad = 0;
    int            cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // open-drain pin: low when either side pulls
    assign hot_n = ~(drive | ext_drive);

    thermal_throttle_arbiter #(.NCORE(NC), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .trip_i(trip), .clkmod_en_i(cm_en),
        .pstate_en_i(ps_en), .hot_pin_n_i(hot_n), .hot_drive_o(drive),
        .clkmod_o(cm_o), .pstate_low_o(ps_o)
    );

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got drive/cm/ps=%b expected %b (trip=%b cm_en=%b ps_en=%b ext=%b)",
                     req, act, exp, trip, cm_en, ps_en, ext_drive);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [4:0] model(input logic [NC-1:0] t, input logic [NC-1:0] c,
                                         input logic [NC-1:0] p, input logic e);
        logic any, ext;
        logic [NC-1:0] ec, ep;
        any = |t;
        ext = e && !any;          // outside request masked while the block drives
        for (int i = 0; i < NC; i++) begin
            ep[i] = p[i] & (any | ext);
            ec[i] = c[i] & (p[i] ? (any | ext) : (t[i] | ext));
        end
        return {any, ec, ep};
    endfunction

    initial begin
        tick(3);
        check("R9 reset", {drive, cm_o, ps_o}, 5'b0);
        rst_n = 1'b1;
        tick(2);
        check("R9 after reset", {drive, cm_o, ps_o}, 5'b0);

        // exhaustive sweep
        for (int k = 0; k < 128; k++) begin
            trip = k[1:0]; cm_en = k[3:2]; ps_en = k[5:4]; ext_drive = k[6];
            tick(4);
            check((trip == 0 && ext_drive) ? "R4 outside request" :
                  (cm_en == 0 && ps_en == 0) ? "R6 no method" :
                  (ext_drive) ? "R5 masked outside" : "R2/R3/R7 internal",
                  {drive, cm_o, ps_o}, model(trip, cm_en, ps_en, ext_drive));
            trip = '0; ext_drive = 1'b0;
            tick(1);
            if (ps_en == 0 && !k[6])
                check("R8 release", {drive, cm_o, ps_o}, 5'b0);
            tick(4);
            check("R8 idle", {drive, cm_o, ps_o}, 5'b0);
        end

        // R8/R1 exact one-cycle timing
        cm_en = 2'b11; ps_en = 2'b00; trip = 2'b01;
        tick(1);
        check("R1 R2 one-cycle assert", {drive, cm_o, ps_o}, 5'b1_01_00);
        trip = 2'b00;
        tick(1);
        check("R8 one-cycle deassert", {drive, cm_o, ps_o}, 5'b0);
        // R5: pin recovery after own drive is not an outside request
        for (int j = 0; j < 4; j++) begin
            tick(1);
            check("R5 no false outside", {drive, cm_o, ps_o}, 5'b0);
        end

        // R4 latency: third rising edge
        ext_drive = 1'b1;
        tick(2);
        check("R4 before latency", {drive, cm_o, ps_o}, 5'b0);
        tick(1);
        check("R4 at latency", {drive, cm_o, ps_o}, 5'b0_11_00);
        ext_drive = 1'b0;
        tick(4);

        // R6: pin still driven with no method
        cm_en = 2'b00; ps_en = 2'b00; trip = 2'b10;
        tick(1);
        check("R6 pin still driven", {drive, cm_o, ps_o}, 5'b1_00_00);
        trip = '0;
        tick(4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule